// File: doc/BRIEF.md
# Multiple-Polynomial LFSR Reseeding Pattern Generator

This block turns compact stored test words into full-length scan patterns. Each incoming word carries two fields: a polynomial selector and a start state. The selector picks one feedback configuration out of a constant table for a Fibonacci (external-XOR) LFSR of width `SEED_W`. The start state is loaded into that LFSR. The LFSR then runs for exactly `SCAN_LEN` clocks. On each of those clocks its low bit is presented on the serial scan output and shifted into an internal `SCAN_LEN`-bit scan register.

A test controller offers words through a valid/ready pair while `run_en` is high. When a pattern finishes, a one-cycle done pulse marks the cycle in which the parallel scan register holds the complete pattern. The storage cost per pattern is `SEL_W + SEED_W` bits.

Top module: `mp_reseed_gen`

## Requirements
- R1: The word is split so that the selector is the upper `SEL_W` bits (`word_data[SEL_W+SEED_W-1:SEED_W]`) and the LFSR start state is the lower `SEED_W` bits (`word_data[SEED_W-1:0]`).
- R2: `word_ready` is high only when no pattern is being shifted and `run_en` is high. A word is taken on a clock edge where both `word_valid` and `word_ready` are high.
- R3: In the first shift cycle after a word is taken, `scan_in` equals bit 0 of the start state.
- R4: Each shift advances the LFSR state s to `{parity(s & mask), s[SEED_W-1:1]}`, where bit j of the mask is the coefficient of x^j. With the defaults, selector 0 gives x^4+x^3+1 (mask 4'b1001) and selector 1 gives x^4+x+1 (mask 4'b0011). Selector 0 with start state 4'b0001 and a 16-bit pattern yields 16'h8F59.
- R5: After a word is taken, `scan_en` is high for exactly `SCAN_LEN` consecutive cycles, and one bit is shifted per cycle.
- R6: Each shifted bit enters `scan_data` at bit 0 and older bits move toward the MSB, so the first bit ends in `scan_data[SCAN_LEN-1]`. `scan_data` does not change while `scan_en` is low.
- R7: `pattern_done` is high for one cycle, the cycle right after the last shift. In that cycle `scan_data` holds the whole pattern, and `word_ready` may already be high so that the next word follows without a gap.
- R8: While `run_en` is low, `word_valid` is ignored and no pattern starts.
- R9: During and after reset, `scan_en`, `pattern_done` and `scan_data` are zero.
- R10: All 2^`SEL_W` selector values are accepted. In the default table, selectors 8 to 15 repeat the masks of selectors 0 to 7 (masks 9,3,F,5,7,B,D,1 in hex).
- R11: `scan_in` is 0 whenever `scan_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enables acceptance of new words |
| word_valid | input | 1 | A stored word is offered |
| word_data | input | SEL_W+SEED_W | Selector (upper) and start state (lower) |
| word_ready | output | 1 | Generator can take a word |
| scan_in | output | 1 | Serial pattern bit for the scan chain |
| scan_en | output | 1 | High during the shift cycles |
| pattern_done | output | 1 | One-cycle pulse after the last shift |
| scan_data | output | SCAN_LEN | Parallel scan register contents |

## Verification
The assertions assume that a word only counts as taken when valid and ready coincide. They also assume that `run_en` is a level which the environment may change at any cycle. The bench drives every input on the falling edge. It holds `word_valid` until the reference model reports a take and then drops it. It also toggles `run_en` only while the generator is idle, or while a word is offered so that the gating can be seen. Because the selectors and start states cover every table entry, including a zero start state, the pattern and done checks never rely on a case the assertions exclude.

// File: rtl/mp_reseed_pkg.sv
package mp_reseed_pkg;

   typedef enum logic [0:0] {
      GEN_IDLE  = 1'b0,
      GEN_SHIFT = 1'b1
   } gen_state_e;

   function automatic int unsigned cnt_width(input int unsigned len);
      int unsigned w;
      w = 1;
      while ((1 << w) <= len) w++;
      return w;
   endfunction

endpackage

// File: rtl/mp_tap_rom.sv
module mp_tap_rom #(
   parameter int unsigned SEED_W = 4,
   parameter int unsigned SEL_W  = 4,
   parameter logic [(2**SEL_W)*SEED_W-1:0] TAP_TABLE = 64'h1DB75F39_1DB75F39
) (
   input  logic [SEL_W-1:0]  sel,
   output logic [SEED_W-1:0] mask
);
   localparam int unsigned NUM_POLY = 2 ** SEL_W;

   logic [SEED_W-1:0] entry [NUM_POLY];

   for (genvar i = 0; i < NUM_POLY; i++) begin : g_entry
      assign entry[i] = TAP_TABLE[i*SEED_W +: SEED_W];
      if (TAP_TABLE[i*SEED_W] != 1'b1) begin : g_bad_p0
         $error("tap table entry lacks the constant term");
      end
   end

   assign mask = entry[sel];

endmodule

// File: rtl/mp_lfsr.sv
module mp_lfsr #(
   parameter int unsigned SEED_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [SEED_W-1:0] seed,
   input  logic [SEED_W-1:0] mask_in,
   output logic              out_bit
);
   logic [SEED_W-1:0] state_q;
   logic [SEED_W-1:0] mask_q;
   logic              fb;

   assign fb      = ^(state_q & mask_q);
   assign out_bit = state_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '0;
         mask_q  <= '0;
      end else if (load) begin
         state_q <= seed;
         mask_q  <= mask_in;
      end else if (step) begin
         state_q <= {fb, state_q[SEED_W-1:1]};
      end
   end

endmodule

// File: rtl/mp_scan_shreg.sv
module mp_scan_shreg #(
   parameter int unsigned SCAN_LEN     = 16,
   parameter bit          FIRST_AT_MSB = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift,
   input  logic                din,
   output logic [SCAN_LEN-1:0] dout
);
   logic [SCAN_LEN-1:0] reg_q;
   logic [SCAN_LEN-1:0] reg_d;

   if (FIRST_AT_MSB) begin : g_fill_lsb
      assign reg_d = {reg_q[SCAN_LEN-2:0], din};
   end else begin : g_fill_msb
      assign reg_d = {din, reg_q[SCAN_LEN-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     reg_q <= '0;
      else if (shift) reg_q <= reg_d;
   end

   assign dout = reg_q;

endmodule

// File: rtl/mp_gen_ctrl.sv
module mp_gen_ctrl
   import mp_reseed_pkg::*;
#(
   parameter int unsigned SCAN_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic word_valid,
   output logic ready,
   output logic load,
   output logic step,
   output logic done
);
   localparam int unsigned CNT_W = cnt_width(SCAN_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_LEN - 1);

   gen_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic             last;

   assign ready = (state_q == GEN_IDLE) && run_en;
   assign load  = ready && word_valid;
   assign step  = (state_q == GEN_SHIFT);
   assign last  = step && (cnt_q == LAST);
   assign done  = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GEN_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (load) begin
            state_q <= GEN_SHIFT;
            cnt_q   <= '0;
         end else if (last) begin
            state_q <= GEN_IDLE;
            cnt_q   <= '0;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/mp_reseed_gen.sv
module mp_reseed_gen #(
   parameter int unsigned SEED_W       = 4,
   parameter int unsigned SEL_W        = 4,
   parameter int unsigned SCAN_LEN     = 16,
   parameter bit          FIRST_AT_MSB = 1'b1,
   parameter logic [(2**SEL_W)*SEED_W-1:0] TAP_TABLE = 64'h1DB75F39_1DB75F39
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_en,
   input  logic                      word_valid,
   input  logic [SEL_W+SEED_W-1:0]   word_data,
   output logic                      word_ready,
   output logic                      scan_in,
   output logic                      scan_en,
   output logic                      pattern_done,
   output logic [SCAN_LEN-1:0]       scan_data
);
   localparam int unsigned WORD_W = SEL_W + SEED_W;

   if (SEED_W < 2)   begin : g_bad_seed $error("SEED_W must be at least 2");   end
   if (SEL_W < 1)    begin : g_bad_sel  $error("SEL_W must be at least 1");    end
   if (SCAN_LEN < 2) begin : g_bad_len  $error("SCAN_LEN must be at least 2"); end

   logic [SEL_W-1:0]  sel;
   logic [SEED_W-1:0] seed;
   logic [SEED_W-1:0] mask;
   logic              load;
   logic              step;
   logic              lfsr_bit;

   assign sel  = word_data[WORD_W-1:SEED_W];
   assign seed = word_data[SEED_W-1:0];

   mp_tap_rom #(
      .SEED_W   (SEED_W),
      .SEL_W    (SEL_W),
      .TAP_TABLE(TAP_TABLE)
   ) u_rom (
      .sel (sel),
      .mask(mask)
   );

   mp_gen_ctrl #(
      .SCAN_LEN(SCAN_LEN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .word_valid(word_valid),
      .ready     (word_ready),
      .load      (load),
      .step      (step),
      .done      (pattern_done)
   );

   mp_lfsr #(
      .SEED_W(SEED_W)
   ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .seed   (seed),
      .mask_in(mask),
      .out_bit(lfsr_bit)
   );

   mp_scan_shreg #(
      .SCAN_LEN    (SCAN_LEN),
      .FIRST_AT_MSB(FIRST_AT_MSB)
   ) u_shreg (
      .clk  (clk),
      .rst_n(rst_n),
      .shift(step),
      .din  (lfsr_bit),
      .dout (scan_data)
   );

   assign scan_en = step;
   assign scan_in = step & lfsr_bit;

endmodule

// File: rtl/mp_reseed_gen_chk.sv
module mp_reseed_gen_chk #(
   parameter int unsigned SCAN_LEN = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                run_en,
   input logic                word_valid,
   input logic                word_ready,
   input logic                scan_in,
   input logic                scan_en,
   input logic                pattern_done,
   input logic [SCAN_LEN-1:0] scan_data
);
   localparam int unsigned LW = 32;

   logic          en_d;
   logic [LW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_d    <= 1'b0;
         run_len <= '0;
      end else begin
         en_d <= scan_en;
         if (scan_en && !en_d) run_len <= LW'(1);
         else if (scan_en)     run_len <= run_len + 1'b1;
      end
   end

   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |-> !word_ready);

   p_run_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !word_ready);

   p_take_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready) |=> scan_en);

   p_shift_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pattern_done |-> (run_len == LW'(SCAN_LEN)));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pattern_done |=> !pattern_done);

   p_done_after_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pattern_done |-> ($past(scan_en) && !scan_en));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |-> !scan_in);

   p_hold_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> $stable(scan_data));

endmodule

bind mp_reseed_gen mp_reseed_gen_chk #(.SCAN_LEN(SCAN_LEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_en      (run_en),
   .word_valid  (word_valid),
   .word_ready  (word_ready),
   .scan_in     (scan_in),
   .scan_en     (scan_en),
   .pattern_done(pattern_done),
   .scan_data   (scan_data)
);

// File: tb/mp_reseed_gen_bench.sv
module mp_reseed_gen_bench;
   localparam int K = 4;
   localparam int Q = 4;
   localparam int M = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           run_en = 1'b0;
   logic           word_valid = 1'b0;
   logic [Q+K-1:0] word_data = '0;
   logic           word_ready;
   logic           scan_in;
   logic           scan_en;
   logic           pattern_done;
   logic [M-1:0]   scan_data;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   mp_reseed_gen u_mp_reseed_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .word_valid  (word_valid),
      .word_data   (word_data),
      .word_ready  (word_ready),
      .scan_in     (scan_in),
      .scan_en     (scan_en),
      .pattern_done(pattern_done),
      .scan_data   (scan_data)
   );

   // reference model
   bit         m_busy, m_done, m_taken;
   int         m_cnt;
   bit [K-1:0] m_lfsr, m_mask;
   bit [M-1:0] m_scan;

   function automatic bit [K-1:0] ref_mask(input int id);
      case (id % 8)
         0: return 4'b1001;   // x^4+x^3+1 (R4)
         1: return 4'b0011;   // x^4+x+1 (R4)
         2: return 4'b1111;
         3: return 4'b0101;
         4: return 4'b0111;
         5: return 4'b1011;
         6: return 4'b1101;
         default: return 4'b0001;
      endcase
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_taken = 0; m_cnt = 0;
         m_lfsr = '0; m_mask = '0; m_scan = '0;
      end else begin
         m_done  = 0;
         m_taken = 0;
         if (m_busy) begin
            bit fb;
            fb = 0;
            m_scan = {m_scan[M-2:0], m_lfsr[0]};
            for (int j = 0; j < K; j++) if (m_mask[j]) fb ^= m_lfsr[j];
            m_lfsr = {fb, m_lfsr[K-1:1]};
            m_cnt++;
            if (m_cnt == M) begin m_busy = 0; m_done = 1; end
         end else if (word_valid && run_en) begin
            m_lfsr  = word_data[K-1:0];
            m_mask  = ref_mask(int'(word_data[Q+K-1:K]));
            m_busy  = 1;
            m_cnt   = 0;
            m_taken = 1;
         end
      end
   end

   task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      chk("R2 word_ready", M'(word_ready), M'(!m_busy && run_en && rst_n));
      chk("R5 scan_en",    M'(scan_en),    M'(m_busy));
      chk("R3/R11 scan_in", M'(scan_in),   M'(m_busy ? m_lfsr[0] : 1'b0));
      chk("R7 pattern_done", M'(pattern_done), M'(m_done));
      chk("R6 scan_data",  scan_data,      m_scan);
   endtask

   task automatic send(input int id, input int seed);
      word_data  = {Q'(id), K'(seed)};
      word_valid = 1'b1;
      do tick(); while (!m_taken);
      word_valid = 1'b0;
      word_data  = '0;
   endtask

   task automatic wait_done();
      do tick(); while (!m_done);
   endtask

   initial begin
      repeat (3) tick();
      // R9: reset values
      chk("R9 reset scan_en", M'(scan_en), '0);
      chk("R9 reset done", M'(pattern_done), '0);
      chk("R9 reset scan_data", scan_data, '0);
      rst_n = 1'b1;
      run_en = 1'b1;
      tick();

      // R4/R1/R3: known pattern for x^4+x^3+1, start state 0001
      send(0, 1);
      chk("R3 first bit is seed[0]", M'(scan_in), M'(1));
      wait_done();
      chk("R4 R7 known pattern 8F59", scan_data, 16'h8F59);
      tick();
      chk("R6 pattern held after done", scan_data, 16'h8F59);

      // R10: every selector, varied seeds
      for (int id = 0; id < 16; id++) begin
         send(id, (id * 5 + 3) % 16);
         wait_done();
      end

      // R7: back-to-back words, next offered during done cycle
      word_data = {4'd1, 4'd9};
      word_valid = 1'b1;
      send(1, 9);
      wait_done();
      word_valid = 1'b1; word_data = {4'd2, 4'd6};
      tick();
      chk("R7 take in done cycle gives scan_en", M'(scan_en), M'(1));
      word_valid = 1'b0;
      wait_done();

      // R8: run_en low ignores words
      run_en = 1'b0;
      word_valid = 1'b1;
      word_data = {4'd3, 4'd5};
      repeat (6) tick();
      chk("R8 no start while run_en low", M'(scan_en), '0);
      word_valid = 1'b0;
      run_en = 1'b1;

      // zero start state stays all-zero (R4)
      send(4, 0);
      wait_done();
      chk("R4 zero seed pattern", scan_data, '0);
      repeat (3) tick();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule